// File: doc/BRIEF.md
# Buffer Interrupt and Empty-Status Controller

This block watches one FIFO buffer set on behalf of the processor that drains it. It decides when that processor should be interrupted. Three independent conditions can raise the interrupt, and each has its own enable:

- **Fill trigger:** the fill level reaches a programmed trigger level.
- **Age timeout:** the buffer has held unread data for a programmed number of cycles.
- **Idle timeout:** no write has arrived for a programmed number of cycles while data is still present.

All three settings sit in a behavioural settings register. Two buffer sets built from the same block can therefore behave differently: a bulk set can use a deep trigger level, and a streaming set can react after a short age timeout.

The interrupt is a level and stays high until one of two things happens: the buffer drains to empty, or software pulses a clear. A cause field shows which conditions have fired since the interrupt was last cleared. The block also gathers the empty flags of up to 32 buffer sets into one registered word. Software polls that word after an interrupt to find out when each set has been drained to a packet boundary.

Top module: `buf_irq_ctrl`

## Requirements
- R1: While reset is held, `irq` is 0, `irq_cause` is 000 and `empty_word` is all zeros. The settings register takes its parameter defaults, which by default enable no cause.
- R2: With cause bit 0 (fill trigger) enabled, when the buffer is not empty and `fill_count` is at least the trigger level at a clock edge, `irq` and `irq_cause[0]` are 1 after that edge. When the fill level is one below the trigger, nothing fires.
- R3: With cause bit 1 (age timeout) enabled and a limit L, suppose the buffer stays non-empty from some edge onward. `irq` and `irq_cause[1]` stay 0 through the first L edges and become 1 after edge L+1.
- R4: With cause bit 2 (idle timeout) enabled and a limit L, suppose data remains and the last write is sampled at edge k. `irq` and `irq_cause[2]` are 0 after edge k+L and 1 after edge k+L+1. A new write restarts this count.
- R5: A cause whose enable bit is 0 never sets its `irq_cause` bit or `irq`, whatever the fill level or timers do.
- R6: `irq` is level sensitive and its cause bits are sticky. It stays 1 after the condition goes away, until an edge samples `irq_clear`=1 or `fifo_empty`=1, which zeroes `irq` and `irq_cause`. Clearing wins over a cause that is active at the same edge; a cause still active afterwards sets `irq` again at the next edge.
- R7: `empty_word[n]` equals `set_empty[n]` as sampled at the previous clock edge, for every set n.
- R8: The settings register loads `cfg_en`, `cfg_thresh`, `cfg_age_lim` and `cfg_idle_lim` only at an edge with `cfg_we`=1. Changes on those inputs at any other time have no effect on the interrupt.
- R9: The age timer restarts whenever the buffer is seen empty. A non-empty stretch shorter than the limit that ends in an empty cycle does not count toward the next stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_count | input | FILL_W (10) | Current fill level of the monitored buffer |
| fifo_empty | input | 1 | Monitored buffer is empty |
| wr_strobe | input | 1 | A write into the monitored buffer was accepted this cycle |
| irq_clear | input | 1 | Software clear of the interrupt and its causes |
| cfg_we | input | 1 | Load the settings register from the cfg_* inputs |
| cfg_en | input | 3 | Cause enables: bit 0 fill trigger, bit 1 age timeout, bit 2 idle timeout |
| cfg_thresh | input | FILL_W (10) | Trigger level |
| cfg_age_lim | input | TMR_W (16) | Age timeout in cycles |
| cfg_idle_lim | input | TMR_W (16) | Idle timeout in cycles |
| set_empty | input | NSETS (32) | Empty flags of the collected buffer sets |
| irq | output | 1 | Interrupt request, level |
| irq_cause | output | 3 | Sticky cause bits, same bit order as cfg_en |
| empty_word | output | NSETS (32) | Registered empty status, bit n for set n |

## Verification
The checker enforces several rules on every cycle:
- the interrupt holds until an empty or clear edge, and either of those zeroes it on the next cycle;
- an enabled fill trigger raises it one edge later;
- a disabled cause never sets its bit;
- the settings stay put without a write strobe;
- the status word tracks the set flags with one cycle of delay.

The exact edge on which each timeout fires, and the restart of the age and idle counts, can only be shown by the bench's timed scenarios. The same holds for the interplay of several sticky causes inside one interrupt episode.

// File: rtl/buf_irq_pkg.sv
package buf_irq_pkg;

    parameter int FILL_W  = 10;
    parameter int TMR_W   = 16;
    parameter int N_CAUSE = 3;

    // cause bit positions, shared by enables and status
    localparam int CAUSE_THR  = 0;
    localparam int CAUSE_AGE  = 1;
    localparam int CAUSE_IDLE = 2;

    typedef struct packed {
        logic [TMR_W-1:0]   idle_lim;
        logic [TMR_W-1:0]   age_lim;
        logic [FILL_W-1:0]  thr;
        logic [N_CAUSE-1:0] en;
    } birq_cfg_t;

    typedef struct packed {
        logic               irq;
        logic [N_CAUSE-1:0] cause;
    } birq_state_t;

endpackage

// File: rtl/birq_cfg_reg.sv
module birq_cfg_reg
    import buf_irq_pkg::*;
#(
    parameter birq_cfg_t RST_VAL = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  birq_cfg_t cfg_in,
    output birq_cfg_t cfg_q
);

    birq_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/birq_timer.sv
// Saturating cycle counter with a compare against a programmable limit.
module birq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         armed,
    input  logic [W-1:0] limit,
    output logic         hit
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = armed && !restart && (cnt_q >= limit);

endmodule

// File: rtl/birq_empty_collect.sv
module birq_empty_collect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_in,
    output logic [N-1:0] word_q
);

    logic [N-1:0] word_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb word_d[i] = flags_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/buf_irq_ctrl.sv
module buf_irq_ctrl
    import buf_irq_pkg::*;
#(
    parameter int                 NSETS    = 32,
    parameter logic [FILL_W-1:0]  DEF_THR  = FILL_W'(16),
    parameter logic [TMR_W-1:0]   DEF_AGE  = TMR_W'(1000),
    parameter logic [TMR_W-1:0]   DEF_IDLE = TMR_W'(200),
    parameter logic [N_CAUSE-1:0] DEF_EN   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FILL_W-1:0]  fill_count,
    input  logic               fifo_empty,
    input  logic               wr_strobe,
    input  logic               irq_clear,
    input  logic               cfg_we,
    input  logic [N_CAUSE-1:0] cfg_en,
    input  logic [FILL_W-1:0]  cfg_thresh,
    input  logic [TMR_W-1:0]   cfg_age_lim,
    input  logic [TMR_W-1:0]   cfg_idle_lim,
    input  logic [NSETS-1:0]   set_empty,
    output logic               irq,
    output logic [N_CAUSE-1:0] irq_cause,
    output logic [NSETS-1:0]   empty_word
);

    localparam birq_cfg_t CFG_RST = '{idle_lim: DEF_IDLE, age_lim: DEF_AGE,
                                      thr: DEF_THR, en: DEF_EN};

    birq_cfg_t          cfg_in, cfg_q;
    logic               age_hit, idle_hit;
    logic [N_CAUSE-1:0] hits;
    birq_state_t        st_d, st_q;

    assign cfg_in = '{idle_lim: cfg_idle_lim, age_lim: cfg_age_lim,
                      thr: cfg_thresh, en: cfg_en};

    birq_cfg_reg #(.RST_VAL(CFG_RST)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    // age: counts cycles of unread data, restarts while empty
    birq_timer #(.W(TMR_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fifo_empty),
        .armed   (!fifo_empty),
        .limit   (cfg_q.age_lim),
        .hit     (age_hit)
    );

    // idle: counts cycles since the last accepted write
    birq_timer #(.W(TMR_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_strobe),
        .armed   (!fifo_empty),
        .limit   (cfg_q.idle_lim),
        .hit     (idle_hit)
    );

    birq_empty_collect #(.N(NSETS)) u_empty (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_in (set_empty),
        .word_q   (empty_word)
    );

    always_comb begin
        hits             = '0;
        hits[CAUSE_THR]  = cfg_q.en[CAUSE_THR] && !fifo_empty && (fill_count >= cfg_q.thr);
        hits[CAUSE_AGE]  = cfg_q.en[CAUSE_AGE] && age_hit;
        hits[CAUSE_IDLE] = cfg_q.en[CAUSE_IDLE] && idle_hit;

        st_d = st_q;
        if (irq_clear || fifo_empty) begin
            st_d.cause = '0;
        end else begin
            st_d.cause = st_q.cause | hits;
        end
        st_d.irq = |st_d.cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.irq;
    assign irq_cause = st_q.cause;

endmodule

module buf_irq_ctrl_chk
    import buf_irq_pkg::*;
#(
    parameter int NSETS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FILL_W-1:0]  fill_count,
    input logic               fifo_empty,
    input logic               irq_clear,
    input logic               cfg_we,
    input birq_cfg_t          cfg_q,
    input logic [NSETS-1:0]   set_empty,
    input logic               irq,
    input logic [N_CAUSE-1:0] irq_cause,
    input logic [NSETS-1:0]   empty_word
);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear && !fifo_empty) |=> irq);

    // R6
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear || fifo_empty) |=> (!irq && irq_cause == '0));

    // R2
    thr_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.en[CAUSE_THR] && !fifo_empty && !irq_clear && fill_count >= cfg_q.thr)
        |=> (irq && irq_cause[CAUSE_THR]));

    // R5
    age_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en[CAUSE_AGE] && !irq_cause[CAUSE_AGE]) |=> !irq_cause[CAUSE_AGE]);

    // R5
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en[CAUSE_IDLE] && !irq_cause[CAUSE_IDLE]) |=> !irq_cause[CAUSE_IDLE]);

    // R8
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    // R7
    empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (empty_word == $past(set_empty)));

endmodule

bind buf_irq_ctrl buf_irq_ctrl_chk #(.NSETS(NSETS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_count (fill_count),
    .fifo_empty (fifo_empty),
    .irq_clear  (irq_clear),
    .cfg_we     (cfg_we),
    .cfg_q      (cfg_q),
    .set_empty  (set_empty),
    .irq        (irq),
    .irq_cause  (irq_cause),
    .empty_word (empty_word)
);

// File: tb/buf_irq_ctrl_test.sv
`timescale 1ns/1ps
module buf_irq_ctrl_test;
    import buf_irq_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [FILL_W-1:0]  fill_count;
    logic               fifo_empty, wr_strobe, irq_clear, cfg_we;
    logic [N_CAUSE-1:0] cfg_en;
    logic [FILL_W-1:0]  cfg_thresh;
    logic [TMR_W-1:0]   cfg_age_lim, cfg_idle_lim;
    logic [31:0]        set_empty;
    logic               irq;
    logic [N_CAUSE-1:0] irq_cause;
    logic [31:0]        empty_word;

    buf_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fill_count(fill_count), .fifo_empty(fifo_empty),
        .wr_strobe(wr_strobe), .irq_clear(irq_clear), .cfg_we(cfg_we), .cfg_en(cfg_en),
        .cfg_thresh(cfg_thresh), .cfg_age_lim(cfg_age_lim), .cfg_idle_lim(cfg_idle_lim),
        .set_empty(set_empty), .irq(irq), .irq_cause(irq_cause), .empty_word(empty_word)
    );

    always #5 clk = ~clk;

    typedef struct {
        string              tag;
        logic               use_word;
        logic               e_irq;
        logic [N_CAUSE-1:0] e_cause;
        logic [31:0]        e_word;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic expect_irq(string tag, logic i, logic [N_CAUSE-1:0] c);
        exp_t e;
        e.tag = tag; e.use_word = 1'b0; e.e_irq = i; e.e_cause = c; e.e_word = '0;
        q.push_back(e);
    endtask

    task automatic expect_all(string tag, logic i, logic [N_CAUSE-1:0] c, logic [31:0] w);
        exp_t e;
        e.tag = tag; e.use_word = 1'b1; e.e_irq = i; e.e_cause = c; e.e_word = w;
        q.push_back(e);
    endtask

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (irq !== e.e_irq || irq_cause !== e.e_cause ||
                (e.use_word && empty_word !== e.e_word)) begin
                n_fail++;
                $display("FAIL %s: irq=%0b cause=%03b word=%08h expected irq=%0b cause=%03b word=%08h",
                         e.tag, irq, irq_cause, empty_word, e.e_irq, e.e_cause, e.e_word);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_cfg(logic [2:0] en, int thr, int age, int idle);
        cfg_en = en;
        cfg_thresh = FILL_W'(thr);
        cfg_age_lim = TMR_W'(age);
        cfg_idle_lim = TMR_W'(idle);
        cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fill_count = '0; fifo_empty = 1'b1; wr_strobe = 1'b0;
        irq_clear = 1'b0; cfg_we = 1'b0; cfg_en = '0; cfg_thresh = '0;
        cfg_age_lim = '0; cfg_idle_lim = '0; set_empty = 32'hFFFF_FFFF;
        step(2);
        expect_all("R1 reset", 1'b0, 3'b000, 32'h0);
        step(1);
        rst_n = 1'b1;
        step(1);
        expect_all("R7 word after reset", 1'b0, 3'b000, 32'hFFFF_FFFF);
        set_empty = 32'hA5A5_0001;
        step(1);
        expect_all("R7 word pattern", 1'b0, 3'b000, 32'hA5A5_0001);
        set_empty = 32'h8000_0000;
        step(1);
        expect_all("R7 top bit", 1'b0, 3'b000, 32'h8000_0000);

        // reset defaults enable nothing
        fifo_empty = 1'b0; fill_count = 10'd1000;
        step(3);
        expect_irq("R1 R5 defaults disabled", 1'b0, 3'b000);
        fifo_empty = 1'b1; fill_count = '0;
        step(1);

        // fill trigger
        load_cfg(3'b001, 8, 5, 4);
        fifo_empty = 1'b0; fill_count = 10'd7;
        step(1);
        expect_irq("R2 below trigger", 1'b0, 3'b000);
        fill_count = 10'd8;
        step(1);
        expect_irq("R2 at trigger", 1'b1, 3'b001);

        // level and clear
        fill_count = 10'd3;
        step(2);
        expect_irq("R6 held after level drops", 1'b1, 3'b001);
        irq_clear = 1'b1;
        step(1);
        expect_irq("R6 clear", 1'b0, 3'b000);
        irq_clear = 1'b0;
        step(1);
        expect_irq("R6 stays clear", 1'b0, 3'b000);
        fill_count = 10'd9;
        step(1);
        expect_irq("R2 refire", 1'b1, 3'b001);
        irq_clear = 1'b1;
        step(1);
        expect_irq("R6 clear wins", 1'b0, 3'b000);
        irq_clear = 1'b0;
        step(1);
        expect_irq("R6 reassert", 1'b1, 3'b001);
        fifo_empty = 1'b1; fill_count = '0;
        step(1);
        expect_irq("R6 drained", 1'b0, 3'b000);

        // settings inputs without write strobe
        cfg_en = 3'b111; cfg_thresh = 10'd1; cfg_age_lim = '0; cfg_idle_lim = '0;
        fifo_empty = 1'b0; fill_count = 10'd2;
        step(3);
        expect_irq("R8 no load without strobe", 1'b0, 3'b000);
        fifo_empty = 1'b1; fill_count = '0;
        step(1);

        // age timeout, limit 5
        load_cfg(3'b010, 8, 5, 4);
        fifo_empty = 1'b0; fill_count = 10'd1;
        step(5);
        expect_irq("R3 before age limit", 1'b0, 3'b000);
        step(1);
        expect_irq("R3 age fired", 1'b1, 3'b010);
        fifo_empty = 1'b1;
        step(1);
        fifo_empty = 1'b0;
        step(3);
        fifo_empty = 1'b1;
        step(1);
        fifo_empty = 1'b0;
        step(5);
        expect_irq("R9 age restarted", 1'b0, 3'b000);
        step(1);
        expect_irq("R9 age fired after restart", 1'b1, 3'b010);
        fifo_empty = 1'b1;
        step(1);

        // idle timeout, limit 4
        load_cfg(3'b100, 8, 5, 4);
        fifo_empty = 1'b0; wr_strobe = 1'b1;
        step(1);
        wr_strobe = 1'b0;
        step(4);
        expect_irq("R4 before idle limit", 1'b0, 3'b000);
        step(1);
        expect_irq("R4 idle fired", 1'b1, 3'b100);
        fifo_empty = 1'b1;
        step(1);
        fifo_empty = 1'b0; wr_strobe = 1'b1;
        step(1);
        wr_strobe = 1'b0;
        step(3);
        wr_strobe = 1'b1;
        step(1);
        wr_strobe = 1'b0;
        step(4);
        expect_irq("R4 write restarts idle", 1'b0, 3'b000);
        step(1);
        expect_irq("R4 idle fired after restart", 1'b1, 3'b100);
        fifo_empty = 1'b1;
        step(1);

        // combined causes accumulate
        load_cfg(3'b111, 8, 5, 100);
        fifo_empty = 1'b0; fill_count = 10'd8; wr_strobe = 1'b1;
        step(1);
        wr_strobe = 1'b0;
        expect_irq("R2 first cause", 1'b1, 3'b001);
        step(4);
        expect_irq("R6 sticky before age", 1'b1, 3'b001);
        step(1);
        expect_irq("R3 R6 age added", 1'b1, 3'b011);
        fifo_empty = 1'b1; fill_count = '0;
        step(1);
        expect_irq("R6 drain clears all", 1'b0, 3'b000);

        step(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule